// File: doc/BRIEF.md
# Banded Tile Background Pixel Fetcher

This block scans a 256x192 tiled screen in the two-colour-per-line banded mode and delivers one 4-bit colour index per pixel clock. For every 8x8 tile it reads three bytes over a single VRAM read port: the tile number from the name table, one line of the tile's pattern, and the matching colour byte. Each pattern bit then picks one of the two colours in the colour byte. The screen is cut into three horizontal bands of eight tile rows each. Every band has its own pattern region and its own colour region, so any tile row can use a distinct set of graphics.

Scanning starts with a one-cycle `start` pulse and runs through all 192 lines without a pause between lines. Each line takes 264 cycles: an 8-cycle prefetch of the first tile, then 256 pixel cycles. During the pixel cycles of each tile, the next tile is fetched. Base addresses come from configuration inputs, which must be held steady for the whole frame.

Top module: `tbg_fetcher`

## Requirements
- R1: After reset, and whenever no frame is in progress, `pix_valid` and `vram_rd` stay low.
- R2: A `start` pulse while idle begins a frame. Each line gives exactly 256 consecutive valid pixels with x counting 0 to 255, followed by 8 invalid cycles. Lines 0 to 191 follow in order, for 49152 pixels per frame.
- R3: The tile number for pixel (x,y) is read at `cfg_name_sel[3:0]`*0x400 + (y/8)*32 + x/8.
- R4: The pattern byte is read at P + (y/64)*0x800 + tile*8 + (y mod 8). P is 0x2000 when `cfg_pattern_sel` bit 2 is 1 and 0x0000 otherwise.
- R5: The colour byte is read at C + (y/64)*0x800 + tile*8 + (y mod 8). C is 0x2000 when `cfg_color_sel` bit 7 is 1 and 0x0000 otherwise.
- R6: Pixel x of a tile uses pattern bit 7-(x mod 8), so the most significant bit comes first. A set bit selects colour-byte bits 7:4 and a clear bit selects bits 3:0.
- R7: If the selected 4-bit colour is 0 (transparent), `pix_color` carries `cfg_backdrop[3:0]` instead.
- R8: VRAM reads never fall on two cycles in a row. A frame issues exactly 3 reads per tile, 18432 in total. Read data is taken one cycle after `vram_rd`.
- R9: A `start` pulse during a frame has no effect on the pixel stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a frame when idle |
| cfg_name_sel | input | 4 | Name table base select, base = value*0x400 |
| cfg_color_sel | input | 8 | Colour table select, bit 7 picks the upper half of VRAM |
| cfg_pattern_sel | input | 8 | Pattern table select, bit 2 picks the upper half of VRAM |
| cfg_backdrop | input | 4 | Colour used for transparent pixels |
| vram_rd | output | 1 | Read strobe for the VRAM port |
| vram_addr | output | 14 | VRAM read address |
| vram_data | input | 8 | Read data, valid one cycle after the strobe |
| pix_valid | output | 1 | A pixel is presented this cycle |
| pix_color | output | 4 | Colour index of the current pixel |

## Verification
The bench builds the block with its default geometry: 32x24 tiles, 8 tile rows per band and a 14-bit VRAM address. This puts all three bands, the full range of tile numbers 0 to 255, and both halves of VRAM for the pattern and colour regions within reach. It fills a VRAM model with a hashed pattern, so any wrong address produces wrong pixels. It runs two frames with opposite base selections, one with a non-zero backdrop and one with a zero backdrop. During the second frame it sends a stray `start` pulse to cover R9.

// File: rtl/tbg_pkg.sv
package tbg_pkg;
    // Tile geometry fixed by the display format
    localparam int TILE_PX = 8;
    localparam int PH_W    = 3;

    typedef enum logic [1:0] {
        SLOT_NONE = 2'd0,
        SLOT_NAME = 2'd1,
        SLOT_PAT  = 2'd2,
        SLOT_COL  = 2'd3
    } fetch_slot_e;
endpackage

// File: rtl/tbg_addr_gen.sv
module tbg_addr_gen
    import tbg_pkg::*;
#(
    parameter int ADDR_W         = 14,
    parameter int H_TILES        = 32,
    parameter int BAND_TILE_ROWS = 8,
    parameter int LINE_W         = 8,
    parameter int TILE_W         = 5
) (
    input  fetch_slot_e         slot,
    input  logic [LINE_W-1:0]   line,
    input  logic [TILE_W-1:0]   tile,
    input  logic [7:0]          name,
    input  logic [3:0]          name_sel,
    input  logic                pat_hi,
    input  logic                col_hi,
    output logic [ADDR_W-1:0]   addr
);
    localparam int NAME_SHIFT = ADDR_W - 4;
    localparam int BAND_LINES = BAND_TILE_ROWS * TILE_PX;
    localparam logic [ADDR_W-1:0] BAND_SPAN = ADDR_W'(H_TILES * BAND_TILE_ROWS * TILE_PX);
    localparam logic [ADDR_W-1:0] HALF      = ADDR_W'(1) << (ADDR_W - 1);
    localparam logic [ADDR_W-1:0] ROW_SPAN  = ADDR_W'(H_TILES);
    localparam logic [LINE_W-1:0] BAND_DIV  = LINE_W'(BAND_LINES);

    logic [ADDR_W-1:0] name_base, tile_row, band_idx, fine_row, glyph_off, band_rel;

    always_comb begin
        name_base = ADDR_W'(name_sel) << NAME_SHIFT;
        tile_row  = ADDR_W'(line[LINE_W-1:PH_W]);
        band_idx  = ADDR_W'(line / BAND_DIV);
        fine_row  = ADDR_W'(line[PH_W-1:0]);
        glyph_off = ADDR_W'(name) << PH_W;
        band_rel  = band_idx * BAND_SPAN + glyph_off + fine_row;
        case (slot)
            SLOT_NAME: addr = name_base + tile_row * ROW_SPAN + ADDR_W'(tile);
            SLOT_PAT:  addr = (pat_hi ? HALF : '0) + band_rel;
            SLOT_COL:  addr = (col_hi ? HALF : '0) + band_rel;
            default:   addr = '0;
        endcase
    end
endmodule

// File: rtl/tbg_pixel_mux.sv
module tbg_pixel_mux (
    input  logic       bit_set,
    input  logic [7:0] color_byte,
    input  logic [3:0] backdrop,
    output logic [3:0] color
);
    logic [3:0] picked;
    always_comb begin
        picked = bit_set ? color_byte[7:4] : color_byte[3:0];
        color  = (picked == 4'd0) ? backdrop : picked;
    end
endmodule

// File: rtl/tbg_fetcher.sv
module tbg_fetcher
    import tbg_pkg::*;
#(
    parameter int ADDR_W         = 14,
    parameter int H_TILES        = 32,
    parameter int V_TILES        = 24,
    parameter int BAND_TILE_ROWS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        cfg_name_sel,
    input  logic [7:0]        cfg_color_sel,
    input  logic [7:0]        cfg_pattern_sel,
    input  logic [3:0]        cfg_backdrop,
    output logic              vram_rd,
    output logic [ADDR_W-1:0] vram_addr,
    input  logic [7:0]        vram_data,
    output logic              pix_valid,
    output logic [3:0]        pix_color
);
    localparam int LINES    = V_TILES * TILE_PX;
    localparam int COLS     = (H_TILES + 1) * TILE_PX;
    localparam int LINE_W   = $clog2(LINES);
    localparam int COL_W    = $clog2(COLS);
    localparam int FT_W     = COL_W - PH_W;
    localparam int TILE_W   = $clog2(H_TILES);
    localparam logic [COL_W-1:0]  COL_LAST  = COL_W'(COLS - 1);
    localparam logic [COL_W-1:0]  LEAD      = COL_W'(TILE_PX);
    localparam logic [COL_W-1:0]  X_LAST    = COL_W'(H_TILES * TILE_PX - 1);
    localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES - 1);
    localparam logic [FT_W-1:0]   FT_END    = FT_W'(H_TILES);

    typedef struct packed {
        logic              busy;
        logic [LINE_W-1:0] line;
        logic [COL_W-1:0]  col;
        logic [7:0]        name;
        logic [7:0]        pat;
        logic [7:0]        colr;
        logic [7:0]        shf;
        logic [7:0]        shc;
    } state_t;

    state_t q, d;
    fetch_slot_e slot;
    logic [PH_W-1:0] phase;
    logic [FT_W-1:0] ftile;
    logic [COL_W-1:0] out_x;

    always_comb begin
        d     = q;
        slot  = SLOT_NONE;
        phase = q.col[PH_W-1:0];
        ftile = q.col[COL_W-1:PH_W];
        if (q.busy) begin
            if (ftile < FT_END) begin
                case (phase)
                    3'd0:    slot = SLOT_NAME;
                    3'd2:    slot = SLOT_PAT;
                    3'd4:    slot = SLOT_COL;
                    default: slot = SLOT_NONE;
                endcase
            end
            case (phase)
                3'd1:    d.name = vram_data;
                3'd3:    d.pat  = vram_data;
                3'd5:    d.colr = vram_data;
                default: ;
            endcase
            if (phase == 3'd7) begin
                d.shf = q.pat;
                d.shc = q.colr;
            end else begin
                d.shf = {q.shf[6:0], 1'b0};
            end
            if (q.col == COL_LAST) begin
                d.col = '0;
                if (q.line == LINE_LAST) d.busy = 1'b0;
                else                     d.line = q.line + 1'b1;
            end else begin
                d.col = q.col + 1'b1;
            end
        end else if (start) begin
            d.busy = 1'b1;
            d.col  = '0;
            d.line = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign vram_rd   = (slot != SLOT_NONE);
    assign pix_valid = q.busy && (q.col >= LEAD);
    assign out_x     = q.col - LEAD;

    tbg_addr_gen #(
        .ADDR_W(ADDR_W), .H_TILES(H_TILES), .BAND_TILE_ROWS(BAND_TILE_ROWS),
        .LINE_W(LINE_W), .TILE_W(TILE_W)
    ) addr_i (
        .slot(slot), .line(q.line), .tile(ftile[TILE_W-1:0]), .name(q.name),
        .name_sel(cfg_name_sel), .pat_hi(cfg_pattern_sel[2]),
        .col_hi(cfg_color_sel[7]), .addr(vram_addr)
    );

    tbg_pixel_mux mux_i (
        .bit_set(q.shf[7]), .color_byte(q.shc),
        .backdrop(cfg_backdrop), .color(pix_color)
    );

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !q.busy |-> (!vram_rd && !pix_valid));

    assert_line_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pix_valid) |-> ($past(out_x) == X_LAST));

    assert_backdrop_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && cfg_backdrop != 4'd0) |-> (pix_color != 4'd0));

    assert_read_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vram_rd |=> !vram_rd);

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && start && q.col != COL_LAST) |=> $stable(q.line));
endmodule

// File: tb/tbg_fetcher_tb_top.sv
module tbg_fetcher_tb_top;
    localparam int FRAME_PIX = 49152;
    localparam int FRAME_RD  = 18432;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [3:0] cfg_name_sel = '0;
    logic [7:0] cfg_color_sel = '0;
    logic [7:0] cfg_pattern_sel = '0;
    logic [3:0] cfg_backdrop = '0;
    logic vram_rd;
    logic [13:0] vram_addr;
    logic [7:0] vram_data = '0;
    logic pix_valid;
    logic [3:0] pix_color;

    logic [7:0] mem [0:16383];
    logic [4:0] exp_q [$];

    int tests = 0;
    int fails = 0;
    int rd_count = 0;
    int pix_count = 0;
    int run_len = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tbg_fetcher dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_name_sel(cfg_name_sel), .cfg_color_sel(cfg_color_sel),
        .cfg_pattern_sel(cfg_pattern_sel), .cfg_backdrop(cfg_backdrop),
        .vram_rd(vram_rd), .vram_addr(vram_addr), .vram_data(vram_data),
        .pix_valid(pix_valid), .pix_color(pix_color)
    );

    // VRAM model with one cycle of read latency (R8)
    always @(posedge clk) if (vram_rd) vram_data <= mem[vram_addr];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: expected pixels from R3..R7, pushed in scan order (R2, R6)
    task automatic push_frame();
        for (int y = 0; y < 192; y++) begin
            for (int x = 0; x < 256; x++) begin
                int na, pa, ca;
                logic [7:0] nm, pt, cb;
                logic [3:0] c;
                logic bk;
                na = int'(cfg_name_sel) * 1024 + (y / 8) * 32 + x / 8;
                nm = mem[na];
                pa = (cfg_pattern_sel[2] ? 8192 : 0) + (y / 64) * 2048 + int'(nm) * 8 + y % 8;
                ca = (cfg_color_sel[7] ? 8192 : 0) + (y / 64) * 2048 + int'(nm) * 8 + y % 8;
                pt = mem[pa];
                cb = mem[ca];
                c = pt[7 - x % 8] ? cb[7:4] : cb[3:0];
                bk = (c == 4'd0);
                if (bk) c = cfg_backdrop;
                exp_q.push_back({bk, c});
            end
        end
    endtask

    // Monitor: pops expectations as pixels appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (vram_rd) rd_count++;
            if (pix_valid) begin
                pix_count++;
                run_len++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected pixel", 1, 0);
                end else begin
                    logic [4:0] e;
                    e = exp_q.pop_front();
                    if (e[4]) check(pix_color == e[3:0], "R7 backdrop pixel", int'(pix_color), int'(e[3:0]));
                    else      check(pix_color == e[3:0], "R3 R4 R5 R6 pixel", int'(pix_color), int'(e[3:0]));
                end
            end else if (run_len != 0) begin
                check(run_len == 256, "R2 line length", run_len, 256);
                run_len = 0;
            end
        end
    end

    task automatic run_frame(input logic [3:0] n2, input logic [7:0] c3,
                             input logic [7:0] p4, input logic [3:0] b7, input bit stray);
        @(negedge clk);
        cfg_name_sel = n2; cfg_color_sel = c3; cfg_pattern_sel = p4; cfg_backdrop = b7;
        push_frame();
        rd_count = 0;
        pix_count = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (stray) begin
            repeat (10000) @(negedge clk);
            start = 1'b1;               // R9: ignored while busy
            @(negedge clk) start = 1'b0;
        end
        while (exp_q.size() != 0) @(negedge clk);
        repeat (20) @(negedge clk);
        check(pix_count == FRAME_PIX, "R2 pixels per frame", pix_count, FRAME_PIX);
        check(rd_count == FRAME_RD, "R8 reads per frame", rd_count, FRAME_RD);
        if (stray) check(pix_count == FRAME_PIX, "R9 stray start no effect", pix_count, FRAME_PIX);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check(!pix_valid && !vram_rd, "R1 idle after frame", int'({pix_valid, vram_rd}), 0);
        end
    endtask

    initial begin
        for (int a = 0; a < 16384; a++)
            mem[a] = 8'((a * 29) ^ (a >> 7) ^ ((a >> 3) * 11) ^ 8'h5A);
        repeat (3) @(negedge clk);
        check(!pix_valid && !vram_rd, "R1 in reset", int'({pix_valid, vram_rd}), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(!pix_valid && !vram_rd, "R1 after reset", int'({pix_valid, vram_rd}), 0);
        run_frame(4'h6, 8'h80, 8'h04, 4'h5, 1'b0);
        run_frame(4'h0, 8'h7F, 8'h03, 4'h0, 1'b1);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", pix_count, FRAME_PIX);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule